// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the 32-bit interrupt control and status word of a seven-channel DMA engine. Software reaches it through a simple port: a read strobe that returns the current word combinationally, and a write strobe with data that is committed on the next rising clock edge. The transfer engines feed it two pulse vectors, one bit per channel. One vector reports that a transfer finished. The other reports a bus error.

Each channel has an interrupt enable and a flag. There is also a master enable, a sticky bus-error bit and a computed master flag. A finished transfer raises its channel's flag only when that channel and the master enable allow it. A bus error always raises both the error bit and the channel's flag. The master flag is true while the error bit is set, or while the master enable is on and any channel flag is set. The interrupt output follows that level.

Six low bits are plain read/write storage. Bits 6 to 14 always read as zero. Events are judged against the enable values held before any write in the same cycle.

Top module: `dma_irq_status`

## Requirements
- R1: After reset the whole word reads as 0x00000000 and `irq` is low.
- R2: A write changes only bits 0-5, bit 15 (the bus-error bit), bits 16-22 (channel 0-6 enables) and bit 23 (the master enable). Bits 6-14 always read as 0. Written values of bits 24-31 are not stored.
- R3: Writing 1 to bit 24+n clears the flag of channel n. Writing 0 there leaves the flag unchanged.
- R4: A completion pulse on channel n sets bit 24+n only when bit 16+n and bit 23 are both 1.
- R5: A bus-error pulse on channel n sets bit 15 and bit 24+n, whatever the enable bits hold.
- R6: Bit 31 reads as bit15 OR (bit23 AND any of bits 24-30). It reflects every write and event from the following cycle.
- R7: `irq` equals bit 31 at all times.
- R8: When an event and a clearing write hit the same flag or the error bit in one cycle, the set wins.
- R9: While `rd_en` is low, `rd_data` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe; enables `rd_data` |
| wr_en | input | 1 | Write strobe; the word is committed at the next edge |
| wr_data | input | 32 | Write data |
| done_evt | input | 7 | Per-channel transfer-complete pulses |
| err_evt | input | 7 | Per-channel bus-error pulses |
| rd_data | output | 32 | Register readback |
| irq | output | 1 | Interrupt level to the interrupt controller |

## Verification
The hardest case to reach is the same-cycle collision. A clearing write and a set event must land on the same flag, or on the error bit, at the same clock edge. The bench reaches it in two steps. It first sets the flag through a normal event. It then drives the write strobe and the event pulse together on one falling edge, so both are sampled at the same rising edge. A second subtle case is a flag left set while the master enable is off. That flag must stay visible on readback and must not raise `irq`. The vector table builds this state deliberately before it clears the flag.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  parameter int CH_N    = 7;
  parameter int DATA_W  = 32;
  parameter int SPARE_W = 6;

  localparam int ERR_POS  = 15;
  localparam int EN_LSB   = 16;
  localparam int MEN_POS  = EN_LSB + CH_N;
  localparam int FLG_LSB  = MEN_POS + 1;
  localparam int MFLG_POS = FLG_LSB + CH_N;

  // Combined master-flag rule, shared so the bench can restate it separately.
  function automatic logic master_calc(input logic err_bit, input logic men,
                                       input logic [CH_N-1:0] flags);
    return err_bit | (men & (|flags));
  endfunction

  // Set condition for one channel flag.
  function automatic logic flag_set(input logic done, input logic err,
                                    input logic en, input logic men);
    return err | (done & en & men);
  endfunction
endpackage

// File: rtl/dirq_wr_decode.sv
module dirq_wr_decode
  import dirq_pkg::*;
(
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              spare_we,
  output logic [SPARE_W-1:0] spare_wd,
  output logic              err_wd,
  output logic [CH_N-1:0]   en_wd,
  output logic              men_wd,
  output logic [CH_N-1:0]   clr_mask
);
  always_comb begin
    spare_we = wr_en;
    spare_wd = wr_data[SPARE_W-1:0];
    err_wd   = wr_data[ERR_POS];
    en_wd    = wr_data[EN_LSB +: CH_N];
    men_wd   = wr_data[MEN_POS];
    clr_mask = wr_en ? wr_data[FLG_LSB +: CH_N] : '0;
  end
endmodule

// File: rtl/dirq_flag_bank.sv
module dirq_flag_bank
  import dirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] done_evt,
  input  logic [CH_N-1:0] err_evt,
  input  logic [CH_N-1:0] en_q,
  input  logic            men_q,
  input  logic [CH_N-1:0] clr_mask,
  output logic [CH_N-1:0] flags_q,
  output logic [CH_N-1:0] set_evt
);
  for (genvar n = 0; n < CH_N; n++) begin : g_ch
    always_comb set_evt[n] = flag_set(done_evt[n], err_evt[n], en_q[n], men_q);

    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[n] <= 1'b0;
      else if (set_evt[n]) flags_q[n] <= 1'b1;
      else if (clr_mask[n]) flags_q[n] <= 1'b0;
    end

    p_err_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[n] |=> flags_q[n]);
    p_done_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt[n] && !err_evt[n] && !(en_q[n] && men_q) && !flags_q[n]) |=> !flags_q[n]);
    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt[n] && en_q[n] && men_q && clr_mask[n]) |=> flags_q[n]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[n] && !done_evt[n] && !err_evt[n]) |=> !flags_q[n]);
  end
endmodule

// File: rtl/dirq_master.sv
module dirq_master
  import dirq_pkg::*;
(
  input  logic            err_q,
  input  logic            men_q,
  input  logic [CH_N-1:0] flags_q,
  output logic            master
);
  always_comb master = master_calc(err_q, men_q, flags_q);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_N-1:0]   done_evt,
  input  logic [CH_N-1:0]   err_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic               spare_we;
  logic [SPARE_W-1:0] spare_wd;
  logic               err_wd;
  logic [CH_N-1:0]    en_wd;
  logic               men_wd;
  logic [CH_N-1:0]    clr_mask;

  logic [SPARE_W-1:0] spare_q;
  logic               err_q;
  logic [CH_N-1:0]    en_q;
  logic               men_q;
  logic [CH_N-1:0]    flags_q;
  logic [CH_N-1:0]    set_evt;
  logic               master;
  logic               any_err_evt;
  logic [DATA_W-1:0]  word;

  dirq_wr_decode u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .spare_we(spare_we), .spare_wd(spare_wd),
    .err_wd(err_wd), .en_wd(en_wd), .men_wd(men_wd), .clr_mask(clr_mask)
  );

  assign any_err_evt = |err_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spare_q <= '0;
      err_q   <= 1'b0;
      en_q    <= '0;
      men_q   <= 1'b0;
    end else begin
      if (spare_we) begin
        spare_q <= spare_wd;
        en_q    <= en_wd;
        men_q   <= men_wd;
      end
      if (any_err_evt) err_q <= 1'b1;
      else if (wr_en)  err_q <= err_wd;
    end
  end

  dirq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .err_evt(err_evt),
    .en_q(en_q), .men_q(men_q), .clr_mask(clr_mask),
    .flags_q(flags_q), .set_evt(set_evt)
  );

  dirq_master u_master (
    .err_q(err_q), .men_q(men_q), .flags_q(flags_q), .master(master)
  );

  always_comb begin
    word = '0;
    word[SPARE_W-1:0]      = spare_q;
    word[ERR_POS]          = err_q;
    word[EN_LSB +: CH_N]   = en_q;
    word[MEN_POS]          = men_q;
    word[FLG_LSB +: CH_N]  = flags_q;
    word[MFLG_POS]         = master;
  end

  assign rd_data = rd_en ? word : '0;
  assign irq     = master;

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_err_evt |=> (err_q && irq));
  p_err_forces_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> irq);
  p_quiet_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_q && flags_q == '0) |-> !irq);
  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_data[MFLG_POS] == irq));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ERR_POS-1:SPARE_W] == '0);
  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/test_dma_irq_status.sv
module test_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  done_evt = '0;
  logic [6:0]  err_evt = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  dma_irq_status i_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .done_evt(done_evt), .err_evt(err_evt), .rd_data(rd_data), .irq(irq)
  );

  typedef struct packed {
    logic        is_wr;
    logic [31:0] data;
    logic [6:0]  done;
    logic [6:0]  err;
    logic [31:0] exp;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 32'hFFFF_FFFF, 7'h00, 7'h00, 32'h80FF_803F, 1'b1}, // R2 R6
    '{1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0000_0000, 1'b0}, // R2
    '{1'b1, 32'h0081_0000, 7'h00, 7'h00, 32'h0081_0000, 1'b0}, // R2
    '{1'b0, 32'h0,         7'h01, 7'h00, 32'h8181_0000, 1'b1}, // R4
    '{1'b0, 32'h0,         7'h02, 7'h00, 32'h8181_0000, 1'b1}, // R4 ch1 disabled
    '{1'b1, 32'h0181_0000, 7'h00, 7'h00, 32'h0081_0000, 1'b0}, // R3
    '{1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0000_0000, 1'b0},
    '{1'b0, 32'h0,         7'h00, 7'h40, 32'hC000_8000, 1'b1}, // R5
    '{1'b1, 32'h4000_0000, 7'h00, 7'h00, 32'h0000_0000, 1'b0}, // R3 R2
    '{1'b1, 32'h0080_0000, 7'h00, 7'h00, 32'h0080_0000, 1'b0},
    '{1'b0, 32'h0,         7'h04, 7'h00, 32'h0080_0000, 1'b0}, // R4 master only
    '{1'b0, 32'h0,         7'h00, 7'h04, 32'h8480_8000, 1'b1}, // R5
    '{1'b1, 32'h0000_8000, 7'h00, 7'h00, 32'h8400_8000, 1'b1}, // R6
    '{1'b1, 32'h0000_0000, 7'h00, 7'h00, 32'h0400_0000, 1'b0}, // R6 flag w/o master
    '{1'b1, 32'h0400_0000, 7'h00, 7'h00, 32'h0000_0000, 1'b0}, // R3
    '{1'b1, 32'h0000_0015, 7'h00, 7'h00, 32'h0000_0015, 1'b0}  // R2 spare bits
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [31:0] d, input logic [6:0] dn,
                       input logic [6:0] er);
    @(negedge clk);
    rd_en = 1'b0; wr_en = w; wr_data = d; done_evt = dn; err_evt = er;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; done_evt = '0; err_evt = '0; rd_en = 1'b1;
    #1;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rd_en = 1'b1;
    #1;
    check("R1 reset word", rd_data, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].is_wr, VT[i].data, VT[i].done, VT[i].err);
      check($sformatf("R2-table vec %0d word", i), rd_data, VT[i].exp);
      check($sformatf("R7 vec %0d irq", i), {31'b0, irq}, {31'b0, VT[i].exp_irq});
    end

    // R9: idle read strobe gives zero.
    @(negedge clk); rd_en = 1'b0; #1;
    check("R9 idle read", rd_data, 32'h0);

    // R8: completion and clearing write together on channel 3.
    drive(1'b1, 32'h0088_0000, 7'h00, 7'h00);
    drive(1'b0, 32'h0, 7'h08, 7'h00);
    check("R4 ch3 set", rd_data, 32'h8888_0000);
    drive(1'b1, 32'h0888_0000, 7'h08, 7'h00);
    check("R8 flag set wins", rd_data, 32'h8888_0000);
    drive(1'b1, 32'h0888_0000, 7'h00, 7'h00);
    check("R3 flag cleared later", rd_data, 32'h0088_0000);

    // R8: bus error and write of 0 to bit 15 together.
    drive(1'b1, 32'h0000_0000, 7'h00, 7'h01);
    check("R8 err bit set wins", rd_data, 32'h8100_8000);
    check("R7 irq on err", {31'b0, irq}, 32'h1);

    // R1: reset mid-run clears everything.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 mid reset word", rd_data, 32'h0);
    check("R1 mid reset irq", {31'b0, irq}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule